// File: doc/BRIEF.md
# Compare-Match Square Wave Timer

The block is an up-counter that advances on a count-clock enable produced by a power-of-two prescaler. Each time the count equals the primary compare value on an enabled tick, the counter returns to zero and keeps counting. On the same tick an output flip-flop inverts, which produces a square wave whose half period is (M+1) count ticks. M is the primary compare value.

Software sets the starting level of the flip-flop through separate set and clear requests. A gate input controls whether the flip-flop appears on the output pin. A second compare value raises its own maskable interrupt pulse and has no effect on the period logic. A run control freezes both the counter and the prescaler. The live count can be read at any time. A primary compare value of zero is not a legal setting: the counter holds at zero and an error flag is raised.

Top module: `sqw_timer`

## Requirements
- R1: After reset, count_o is 0 and wave_o, irq0_o, irq1_o and cfg_err_o are all 0.
- R2: While run_i is 1, the counter advances by one on every count tick. A tick occurs once every 2^presc_sel_i clock cycles. With presc_sel_i = 0, a tick occurs on every cycle.
- R3: On a tick where count_o equals a nonzero cmp0_i, the counter goes to 0 on the following edge. The flip-flop therefore toggles every (cmp0_i+1)·2^presc_sel_i cycles.
- R4: Each primary match inverts the output flip-flop. On the same edge, irq0_o goes high for exactly one cycle.
- R5: If lvl_set_i is 1 and lvl_clr_i is 0, the flip-flop is loaded with 1 on the next edge. If lvl_clr_i is 1 and lvl_set_i is 0, it is loaded with 0. If both are 1, the flip-flop keeps its value. A level request takes priority over a match toggle.
- R6: wave_o equals the flip-flop while out_en_i is 1. When out_en_i is 0, wave_o is 0 in the same cycle.
- R7: On a tick where count_o equals cmp1_i, irq1_o pulses high one edge later, unless irq1_mask_i is 1. This match does not change count_o or wave_o.
- R8: While cmp0_i is 0, ticks hold the counter at 0 and the flip-flop does not toggle. cfg_err_o is 1 one cycle after cmp0_i becomes 0.
- R9: While run_i is 0, count_o and the prescaler phase do not change.
- R10: count_o always shows the live counter value. Reading it has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | 1 = count, 0 = freeze counter and prescaler |
| presc_sel_i | input | 2 | Prescale select, tick every 2^sel cycles |
| cmp0_i | input | 16 | Primary compare (period) value |
| cmp1_i | input | 16 | Secondary compare value |
| lvl_set_i | input | 1 | Load flip-flop with 1 |
| lvl_clr_i | input | 1 | Load flip-flop with 0 |
| out_en_i | input | 1 | Output gate for wave_o |
| irq1_mask_i | input | 1 | 1 = suppress secondary interrupt |
| count_o | output | 16 | Live counter value |
| wave_o | output | 1 | Gated square wave |
| irq0_o | output | 1 | Primary match pulse |
| irq1_o | output | 1 | Secondary match pulse |
| cfg_err_o | output | 1 | Primary compare is zero |

## Verification
count_o, the flip-flop, irq0_o and irq1_o all change on the edge that ends a tick cycle, so a match on tick cycle n is visible in the sample taken after edge n. cfg_err_o follows cmp0_i one edge later. wave_o responds to out_en_i within the same cycle. The bench drives inputs and samples outputs on the falling clock edge. Period checks count falling edges between two successive wave_o changes and compare the result with (M+1)·2^sel. The pulse checks look at the sample where the toggle appears and at the sample after it.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
  localparam int unsigned CNT_W_DEF = 16;
  localparam int unsigned SEL_W_DEF = 2;
  typedef enum logic [1:0] {LVL_HOLD, LVL_SET, LVL_CLR} lvl_req_e;
endpackage

// File: rtl/sqw_prescaler.sv
module sqw_prescaler #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned DIV_W = (2 ** SEL_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W:0]   mask_w;
  logic [DIV_W-1:0] mask;

  // mask has sel low bits set
  assign mask_w = ({{DIV_W{1'b0}}, 1'b1} << sel_i) - 1'b1;
  assign mask   = mask_w[DIV_W-1:0];
  assign tick_o = run_i && ((div_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    div_q <= '0;
    else if (run_i) div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/sqw_counter.sv
module sqw_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cmp0_i,
  input  logic [CNT_W-1:0] cmp1_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match0_o,
  output logic             match1_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             cmp0_zero;

  assign cmp0_zero = (cmp0_i == '0);
  assign match0_o  = tick_i && !cmp0_zero && (cnt_q == cmp0_i);
  assign match1_o  = tick_i && (cnt_q == cmp1_i);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cmp0_zero || match0_o) cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sqw_outff.sv
module sqw_outff
  import sqw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic toggle_i,
  output logic ff_o
);
  lvl_req_e req;
  logic     ff_q;

  always_comb begin
    unique case ({set_i, clr_i})
      2'b10:   req = LVL_SET;
      2'b01:   req = LVL_CLR;
      default: req = LVL_HOLD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff_q <= 1'b0;
    end else begin
      unique case (req)
        LVL_SET: ff_q <= 1'b1;
        LVL_CLR: ff_q <= 1'b0;
        default: if (toggle_i && !(set_i && clr_i)) ff_q <= ~ff_q;
      endcase
    end
  end

  assign ff_o = ff_q;
endmodule

// File: rtl/sqw_timer.sv
module sqw_timer
  import sqw_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF,
  parameter int unsigned SEL_W = SEL_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] presc_sel_i,
  input  logic [CNT_W-1:0] cmp0_i,
  input  logic [CNT_W-1:0] cmp1_i,
  input  logic             lvl_set_i,
  input  logic             lvl_clr_i,
  input  logic             out_en_i,
  input  logic             irq1_mask_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wave_o,
  output logic             irq0_o,
  output logic             irq1_o,
  output logic             cfg_err_o
);
  logic tick, match0, match1, ff;
  logic irq0_q, irq1_q, err_q;

  sqw_prescaler #(.SEL_W(SEL_W)) u_psc (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i),
    .sel_i(presc_sel_i), .tick_o(tick)
  );

  sqw_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .cmp0_i(cmp0_i), .cmp1_i(cmp1_i), .cnt_o(count_o),
    .match0_o(match0), .match1_o(match1)
  );

  sqw_outff u_ff (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(lvl_set_i),
    .clr_i(lvl_clr_i), .toggle_i(match0), .ff_o(ff)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq0_q <= 1'b0;
      irq1_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      irq0_q <= match0;
      irq1_q <= match1 && !irq1_mask_i;
      err_q  <= (cmp0_i == '0);
    end
  end

  assign irq0_o    = irq0_q;
  assign irq1_o    = irq1_q;
  assign cfg_err_o = err_q;
  assign wave_o    = out_en_i & ff;
endmodule

// File: rtl/sqw_timer_chk.sv
module sqw_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             lvl_set_i,
  input logic             lvl_clr_i,
  input logic             out_en_i,
  input logic             irq1_mask_i,
  input logic [CNT_W-1:0] count_o,
  input logic             wave_o,
  input logic             irq0_o,
  input logic             irq1_o,
  input logic             cfg_err_o
);
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + 1'b1) || (count_o == '0));

  a_r3_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq0_o |-> (count_o == '0));

  a_r4_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq0_o |=> !irq0_o);

  a_r5_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_set_i && !lvl_clr_i) |=> (wave_o || !out_en_i));

  a_r6_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_i |-> !wave_o);

  a_r7_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq1_mask_i |=> !irq1_o);

  a_r8_no_irq0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !irq0_o);

  a_r9_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(count_o));
endmodule

bind sqw_timer sqw_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i),
  .lvl_set_i(lvl_set_i), .lvl_clr_i(lvl_clr_i), .out_en_i(out_en_i),
  .irq1_mask_i(irq1_mask_i), .count_o(count_o), .wave_o(wave_o),
  .irq0_o(irq0_o), .irq1_o(irq1_o), .cfg_err_o(cfg_err_o)
);

// File: tb/tb_sqw_timer.sv
`timescale 1ns/1ps
module tb_sqw_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [1:0]  sel = '0;
  logic [15:0] cmp0 = 16'hFFFF;
  logic [15:0] cmp1 = 16'hFFFF;
  logic        lset = 1'b0, lclr = 1'b0, oen = 1'b0, mask = 1'b0;
  logic [15:0] count;
  logic        wave, irq0, irq1, err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  sqw_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .presc_sel_i(sel),
    .cmp0_i(cmp0), .cmp1_i(cmp1), .lvl_set_i(lset), .lvl_clr_i(lclr),
    .out_en_i(oen), .irq1_mask_i(mask), .count_o(count), .wave_o(wave),
    .irq0_o(irq0), .irq1_o(irq1), .cfg_err_o(err)
  );

  // {sel[3:0], cmp0[15:0]}
  localparam logic [19:0] VEC [6] = '{
    {4'd0, 16'd1}, {4'd0, 16'd5}, {4'd1, 16'd3},
    {4'd2, 16'd2}, {4'd3, 16'd4}, {4'd0, 16'd32}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    run = 1'b0; lset = 1'b0; lclr = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    logic prev;
    bit seen;
    step(2);
    check("R1 count", int'(count), 0);
    check("R1 wave", int'(wave), 0);
    check("R1 irq0", int'(irq0), 0);
    check("R1 irq1", int'(irq1), 0);
    check("R1 err", int'(err), 0);
    rst_n = 1'b1;
    step(1);

    // table of period vectors: R3, R4
    for (int i = 0; i < 6; i++) begin
      do_reset();
      sel = VEC[i][17:16];
      cmp0 = VEC[i][15:0];
      cmp1 = 16'hFFFF;
      oen = 1'b1;
      run = 1'b1;
      prev = wave;
      n = 0;
      while (wave == prev && n < 2000) begin step(1); n++; end
      check("R4 irq0 at toggle", int'(irq0), 1);
      check("R3 count zero at wrap", int'(count), 0);
      prev = wave;
      step(1);
      n = 1;
      check("R4 irq0 single pulse", int'(irq0), 0);
      while (wave == prev && n < 2000) begin step(1); n++; end
      check("R3 toggle period", n, (int'(VEC[i][15:0]) + 1) << VEC[i][17:16]);
    end

    // R2, R10 counting and R9 freeze
    do_reset();
    sel = 2'd0; cmp0 = 16'hFFFF; cmp1 = 16'hFFFF; run = 1'b1;
    step(10);
    check("R2 count after 10 ticks", int'(count), 10);
    check("R10 read no side effect", int'(count), 10);
    run = 1'b0;
    step(5);
    check("R9 count frozen", int'(count), 10);
    sel = 2'd2; run = 1'b1;
    step(8);
    check("R2 prescale by 4", int'(count), 12);
    run = 1'b0;
    step(7);
    check("R9 prescaler frozen count", int'(count), 12);
    run = 1'b1;
    step(4);
    check("R9 prescaler phase kept", int'(count), 13);
    run = 1'b0;

    // R5 levels, R6 gate
    oen = 1'b1;
    lset = 1'b1; step(1); lset = 1'b0;
    check("R5 set", int'(wave), 1);
    lset = 1'b1; lclr = 1'b1; step(1); lset = 1'b0; lclr = 1'b0;
    check("R5 both hold high", int'(wave), 1);
    oen = 1'b0; #1;
    check("R6 gated low", int'(wave), 0);
    oen = 1'b1; #1;
    check("R6 ungated", int'(wave), 1);
    step(1);
    lclr = 1'b1; step(1); lclr = 1'b0;
    check("R5 clear", int'(wave), 0);
    lset = 1'b1; lclr = 1'b1; step(1); lset = 1'b0; lclr = 1'b0;
    check("R5 both hold low", int'(wave), 0);

    // R7 secondary match
    do_reset();
    sel = 2'd0; cmp0 = 16'd20; cmp1 = 16'd7; mask = 1'b0; oen = 1'b1; run = 1'b1;
    step(8);
    check("R7 irq1 pulse", int'(irq1), 1);
    check("R7 count unaffected", int'(count), 8);
    step(1);
    check("R7 irq1 one cycle", int'(irq1), 0);
    check("R7 wave unaffected", int'(wave), 0);
    do_reset();
    mask = 1'b1; run = 1'b1;
    seen = 1'b0;
    for (int k = 0; k < 30; k++) begin step(1); if (irq1) seen = 1'b1; end
    check("R7 masked irq1", int'(seen), 0);
    mask = 1'b0;

    // R8 zero compare
    do_reset();
    cmp0 = 16'd0; cmp1 = 16'd5; run = 1'b1; oen = 1'b1;
    step(1);
    check("R8 err flag", int'(err), 1);
    seen = 1'b0;
    for (int k = 0; k < 20; k++) begin step(1); if (irq0 || wave) seen = 1'b1; end
    check("R8 no toggle", int'(seen), 0);
    check("R8 count held", int'(count), 0);
    cmp0 = 16'd9;
    step(1);
    check("R8 err clears", int'(err), 0);
    run = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule